// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Unit

This block turns register writes into inter-processor interrupt messages. Software first programs a destination word, then writes a command word. The command word carries the interrupt vector, the delivery mode, the destination mode, the level and trigger bits, and a two-bit shorthand. Writing the command word is what starts the send. From then on a busy flag stays raised, and the message is held on a valid/ready output until the interrupt fabric accepts it.

With each message the block also delivers a target mask with one bit per processor. The mask is derived from the shorthand, the destination mode, the destination ID and the block's own processor ID. Misuse does not stop the block. A command written while a send is still outstanding, or a command that names the reserved delivery mode, is dropped and recorded in an error accumulator. Software captures that accumulator into a readable error register by writing the error register.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset no message is offered (`msgValid` low), and all three registers read back zero.
- R2: A command write (`wrSel`=0) made while no send is outstanding latches the command fields. The delivery mode must not be 3. The fields are vector in bits 7:0, delivery mode in bits 10:8, logical destination in bit 11, level in bit 14, trigger in bit 15 and shorthand in bits 19:18. From the next cycle `msgValid` is high and bit 12 of the command readback reads 1. All other readback bits are 0.
- R3: The outgoing message carries the latched vector, mode, destination-mode, level and trigger values. `msgValid` and the busy bit stay high until a cycle in which `msgReady` is also high, and are low in the cycle after that handshake.
- R4: A command write made while a send is outstanding changes nothing about the outstanding message, and it sets error bit 0 (busy violation) in the accumulator.
- R5: A command write with delivery mode 3 sends nothing and leaves the latched command unchanged, and it sets error bit 1 (reserved mode) in the accumulator.
- R6: A destination write (`wrSel`=1) stores bits 31:24 as the destination ID and reads back with all other bits 0. It is ignored while a send is outstanding.
- R7: With shorthand 0 in physical mode, the target mask is the one-hot bit of the destination ID when that ID is below `NumCpus`, all ones when the ID is 0xFF, and zero otherwise. In logical mode the mask is the destination ID's low bits, one bit per processor.
- R8: Shorthand 1 targets only the processor named by `selfId`. Shorthand 2 targets every processor. Shorthand 3 targets every processor except `selfId`.
- R9: A write to the error register (`wrSel`=2) copies the accumulator into the readable error register and clears the accumulator. An error raised in that same cycle is kept for the next capture. `wrSel`=3 reads zero.
- R10: A start-up message (mode 6) carries the vector field unchanged, as the page number of the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 command, 1 destination, 2 error |
| wrData | input | 32 | Write data |
| rdSel | input | 2 | Read select, same encoding as `wrSel` |
| rdData | output | 32 | Combinational read data |
| selfId | input | 8 | ID of the processor this block belongs to |
| msgValid | output | 1 | Message offered (equals the busy bit) |
| msgReady | input | 1 | Fabric accepts the message |
| msgVector | output | 8 | Vector or start-up page |
| msgMode | output | 3 | Delivery mode |
| msgLogical | output | 1 | Logical destination mode |
| msgLevel | output | 1 | Level bit |
| msgTrigger | output | 1 | Trigger mode bit |
| msgTargets | output | NumCpus | Expanded target mask |

## Verification
A busy bit that is stuck or set wrongly shows up within one cycle. It appears as `msgValid` that will not drop after a handshake, or as a second command that starts a send when it should have been refused. A corrupted latched field appears on the message outputs and in the command readback in the cycle after the write. A wrong accumulator only becomes visible after the next error-register write, so the reference model compares every readback selection on every clock and captures the accumulator often.

// File: rtl/ipi_cmd_pkg.sv
`timescale 1ns/1ps
package ipi_cmd_pkg;
  localparam int IdW  = 8;
  localparam int VecW = 8;

  typedef enum logic [1:0] {SEL_CMD = 2'd0, SEL_DEST = 2'd1, SEL_ERR = 2'd2, SEL_NONE = 2'd3} regSel_e;
  typedef enum logic [2:0] {
    MODE_FIXED = 3'd0, MODE_LOWPRI = 3'd1, MODE_SMI = 3'd2, MODE_RSVD = 3'd3,
    MODE_NMI = 3'd4, MODE_INIT = 3'd5, MODE_START = 3'd6, MODE_EXT = 3'd7
  } dlvMode_e;
  typedef enum logic [1:0] {SH_DEST = 2'd0, SH_SELF = 2'd1, SH_ALL = 2'd2, SH_OTHERS = 2'd3} shorthand_e;

  typedef struct packed {
    logic [VecW-1:0] vector;
    dlvMode_e        mode;
    logic            logical;
    logic            level;
    logic            trigger;
    shorthand_e      shorthand;
  } cmdWord_t;

  typedef struct packed {
    logic loadCmd;
    logic loadDest;
    logic snapErr;
    logic setBusyErr;
    logic setModeErr;
  } ctrlStrb_t;
endpackage

// File: rtl/ipi_cmd_ctrl.sv
`timescale 1ns/1ps
module ipi_cmd_ctrl
  import ipi_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic [1:0] wrSel,
  input  logic [2:0] wrMode,
  input  logic      msgReady,
  output ctrlStrb_t strb,
  output logic      busy
);
  logic cmdWr, rsvdMode, accepted;

  always_comb begin
    cmdWr           = wrEn && (regSel_e'(wrSel) == SEL_CMD);
    rsvdMode        = (dlvMode_e'(wrMode) == MODE_RSVD);
    accepted        = busy && msgReady;
    strb.loadCmd    = cmdWr && !busy && !rsvdMode;
    strb.setBusyErr = cmdWr && busy;
    strb.setModeErr = cmdWr && !busy && rsvdMode;
    strb.loadDest   = wrEn && (regSel_e'(wrSel) == SEL_DEST) && !busy;
    strb.snapErr    = wrEn && (regSel_e'(wrSel) == SEL_ERR);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busy <= 1'b0;
    else if (strb.loadCmd) busy <= 1'b1;
    else if (accepted)     busy <= 1'b0;
  end
endmodule

// File: rtl/ipi_cmd_dpath.sv
`timescale 1ns/1ps
module ipi_cmd_dpath
  import ipi_cmd_pkg::*;
#(
  parameter int NumCpus = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic               busy,
  input  logic [31:0]        wrData,
  input  logic [1:0]         rdSel,
  input  logic [IdW-1:0]     selfId,
  output logic [31:0]        rdData,
  output cmdWord_t           cmd,
  output logic [NumCpus-1:0] targets
);
  localparam int ExtW = (NumCpus > IdW) ? NumCpus : IdW;

  logic [IdW-1:0]  destId;
  logic [1:0]      errAcc, errVis, errNew;
  logic [ExtW-1:0] destWide;
  logic [NumCpus-1:0] selfMask, destMask;

  assign errNew = {strb.setModeErr, strb.setBusyErr};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmd    <= '0;
      destId <= '0;
      errAcc <= '0;
      errVis <= '0;
    end else begin
      if (strb.loadCmd) begin
        cmd.vector    <= wrData[7:0];
        cmd.mode      <= dlvMode_e'(wrData[10:8]);
        cmd.logical   <= wrData[11];
        cmd.level     <= wrData[14];
        cmd.trigger   <= wrData[15];
        cmd.shorthand <= shorthand_e'(wrData[19:18]);
      end
      if (strb.loadDest) destId <= wrData[31:24];
      if (strb.snapErr) begin
        errVis <= errAcc;
        errAcc <= errNew;
      end else begin
        errAcc <= errAcc | errNew;
      end
    end
  end

  always_comb begin
    destWide = ExtW'(destId);
    for (int i = 0; i < NumCpus; i++) begin
      selfMask[i] = (selfId == IdW'(i));
      destMask[i] = cmd.logical ? destWide[i]
                                : ((destId == IdW'(i)) || (destId == '1));
    end
    unique case (cmd.shorthand)
      SH_DEST:   targets = destMask;
      SH_SELF:   targets = selfMask;
      SH_ALL:    targets = '1;
      SH_OTHERS: targets = ~selfMask;
    endcase
  end

  always_comb begin
    unique case (regSel_e'(rdSel))
      SEL_CMD:  rdData = {12'b0, cmd.shorthand, 2'b0, cmd.trigger, cmd.level, 1'b0,
                          busy, cmd.logical, cmd.mode, cmd.vector};
      SEL_DEST: rdData = {destId, 24'b0};
      SEL_ERR:  rdData = {30'b0, errVis};
      SEL_NONE: rdData = '0;
    endcase
  end
endmodule

// File: rtl/ipi_cmd_unit.sv
`timescale 1ns/1ps
module ipi_cmd_unit
  import ipi_cmd_pkg::*;
#(
  parameter int NumCpus = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [31:0]        wrData,
  input  logic [1:0]         rdSel,
  output logic [31:0]        rdData,
  input  logic [7:0]         selfId,
  output logic               msgValid,
  input  logic               msgReady,
  output logic [7:0]         msgVector,
  output logic [2:0]         msgMode,
  output logic               msgLogical,
  output logic               msgLevel,
  output logic               msgTrigger,
  output logic [NumCpus-1:0] msgTargets
);
  ctrlStrb_t strb;
  cmdWord_t  cmd;
  logic      busy;

  ipi_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrMode(wrData[10:8]),
    .msgReady(msgReady), .strb(strb), .busy(busy)
  );

  ipi_cmd_dpath #(.NumCpus(NumCpus)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .wrData(wrData),
    .rdSel(rdSel), .selfId(selfId), .rdData(rdData), .cmd(cmd), .targets(msgTargets)
  );

  assign msgValid   = busy;
  assign msgVector  = cmd.vector;
  assign msgMode    = cmd.mode;
  assign msgLogical = cmd.logical;
  assign msgLevel   = cmd.level;
  assign msgTrigger = cmd.trigger;
endmodule

// File: rtl/ipi_cmd_unit_chk.sv
`timescale 1ns/1ps
module ipi_cmd_unit_chk #(
  parameter int NumCpus = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  wrSel,
  input logic [31:0] wrData,
  input logic        msgValid,
  input logic        msgReady,
  input logic [7:0]  msgVector,
  input logic [2:0]  msgMode
);
  logic cmdWr;
  assign cmdWr = wrEn && (wrSel == 2'd0);

  // R2
  send_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!msgValid && cmdWr && wrData[10:8] != 3'd3) |=> msgValid);

  // R3
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgVector) && $stable(msgMode)));

  // R3
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> !msgValid);

  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady && cmdWr) |=> ($stable(msgVector) && $stable(msgMode)));

  // R5
  rsvd_no_send_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!msgValid && cmdWr && wrData[10:8] == 3'd3) |=> !msgValid);
endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk #(.NumCpus(NumCpus)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .msgValid(msgValid), .msgReady(msgReady), .msgVector(msgVector), .msgMode(msgMode)
);

// File: tb/ipi_cmd_unit_tb.sv
`timescale 1ns/1ps
module ipi_cmd_unit_tb;
  localparam int N = 8;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, msgReady = 1'b0;
  logic [1:0] wrSel = 2'd0, rdSel = 2'd0;
  logic [31:0] wrData = '0;
  logic [7:0] selfId = 8'd2;
  logic [31:0] rdData;
  logic msgValid, msgLogical, msgLevel, msgTrigger;
  logic [7:0] msgVector;
  logic [2:0] msgMode;
  logic [N-1:0] msgTargets;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state
  int mBusy, mVec, mMode, mLog, mLvl, mTrig, mSh, mDest, mAcc, mVis;

  always #4 clk = ~clk;

  ipi_cmd_unit #(.NumCpus(N)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .selfId(selfId), .msgValid(msgValid),
    .msgReady(msgReady), .msgVector(msgVector), .msgMode(msgMode),
    .msgLogical(msgLogical), .msgLevel(msgLevel), .msgTrigger(msgTrigger),
    .msgTargets(msgTargets)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] expTargets();
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) begin
      case (mSh)
        0: m[i] = mLog ? ((mDest >> i) & 1) != 0 : (mDest == i || mDest == 255);
        1: m[i] = (selfId == i);
        2: m[i] = 1'b1;
        default: m[i] = (selfId != i);
      endcase
    end
    return m;
  endfunction

  function automatic logic [31:0] expRead(input int sel);
    case (sel)
      0: return (mSh << 18) | (mTrig << 15) | (mLvl << 14) | (mBusy << 12) |
                (mLog << 11) | (mMode << 8) | mVec;
      1: return mDest << 24;
      2: return mVis;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mVec = 0; mMode = 0; mLog = 0; mLvl = 0; mTrig = 0;
      mSh = 0; mDest = 0; mAcc = 0; mVis = 0;
    end else begin
      int nAcc, nBusy;
      nAcc = mAcc;
      nBusy = (mBusy != 0 && msgReady) ? 0 : mBusy;
      if (wrEn && wrSel == 2) begin mVis = mAcc; nAcc = 0; end
      if (wrEn && wrSel == 0) begin
        if (mBusy != 0) nAcc |= 1;
        else if (wrData[10:8] == 3) nAcc |= 2;
        else begin
          mVec = wrData[7:0]; mMode = wrData[10:8]; mLog = wrData[11];
          mLvl = wrData[14]; mTrig = wrData[15]; mSh = wrData[19:18];
          nBusy = 1;
        end
      end
      if (wrEn && wrSel == 1 && mBusy == 0) mDest = wrData[31:24];
      mAcc = nAcc;
      mBusy = nBusy;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R3 valid", {31'b0, msgValid}, mBusy);
      chk("R2 readback", rdData, expRead(rdSel));
      if (msgValid) begin
        chk("R3 fields", {msgTrigger, msgLevel, msgLogical, msgMode, msgVector},
            {mTrig[0], mLvl[0], mLog[0], mMode[2:0], mVec[7:0]});
        chk("R8 targets", msgTargets, expTargets());
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); #1;
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] sel, input logic [31:0] exp);
    rdSel = sel; #1;
    chk(tag, rdData, exp);
  endtask

  function automatic logic [31:0] cmdW(input int vec, input int mode, input int lg, input int sh);
    return (sh << 18) | (1 << 14) | (lg << 11) | (mode << 8) | vec;
  endfunction

  task automatic sendAndDrain();
    @(negedge clk); #1; msgReady = 1'b1;
    @(negedge clk); #1; msgReady = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    chk("R1 valid", {31'b0, msgValid}, 0);
    rd("R1 cmd", 2'd0, 0); rd("R1 dest", 2'd1, 0); rd("R1 err", 2'd2, 0);

    // R6 / R2 / R7 physical single target
    wr(2'd1, 32'h0300_0000);
    rd("R6 dest", 2'd1, 32'h0300_0000);
    wr(2'd0, cmdW(8'h41, 0, 0, 0));
    chk("R2 valid", {31'b0, msgValid}, 1);
    rd("R2 pending bit", 2'd0, 32'h0000_5041);
    chk("R7 phys onehot", msgTargets, 8'h08);
    // R4 write while busy
    wr(2'd0, cmdW(8'h77, 4, 1, 2));
    chk("R4 vector kept", msgVector, 8'h41);
    // R6 dest ignored while busy
    wr(2'd1, 32'h0500_0000);
    rd("R6 dest busy", 2'd1, 32'h0300_0000);
    sendAndDrain();
    chk("R3 dropped", {31'b0, msgValid}, 0);
    // R9 capture
    wr(2'd2, 0);
    rd("R9 busy err", 2'd2, 1);
    // R5 reserved mode
    wr(2'd0, cmdW(8'h10, 3, 0, 0));
    chk("R5 no send", {31'b0, msgValid}, 0);
    rd("R5 cmd unchanged", 2'd0, 32'h0000_4041);
    wr(2'd2, 0);
    rd("R9 mode err", 2'd2, 2);
    wr(2'd2, 0);
    rd("R9 cleared", 2'd2, 0);
    rd("R9 sel3 zero", 2'd3, 0);

    // R8 shorthands with selfId=2
    wr(2'd0, cmdW(8'h20, 0, 0, 1));
    chk("R8 self", msgTargets, 8'h04); sendAndDrain();
    wr(2'd0, cmdW(8'h21, 0, 0, 2));
    chk("R8 all", msgTargets, 8'hFF); sendAndDrain();
    wr(2'd0, cmdW(8'h22, 4, 0, 3));
    chk("R8 others", msgTargets, 8'hFB); sendAndDrain();

    // R7 logical, broadcast, out of range
    wr(2'd1, 32'hA500_0000);
    wr(2'd0, cmdW(8'h30, 1, 1, 0));
    chk("R7 logical", msgTargets, 8'hA5); sendAndDrain();
    wr(2'd1, 32'hFF00_0000);
    wr(2'd0, cmdW(8'h31, 0, 0, 0));
    chk("R7 broadcast", msgTargets, 8'hFF); sendAndDrain();
    wr(2'd1, 32'h2000_0000);
    wr(2'd0, cmdW(8'h32, 0, 0, 0));
    chk("R7 out of range", msgTargets, 8'h00); sendAndDrain();

    // R10 start-up page
    wr(2'd0, cmdW(8'h9A, 6, 0, 0));
    chk("R10 page", {21'b0, msgMode, msgVector}, 32'h69A); sendAndDrain();

    // random phase, compared by the model every clock
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); #1;
      wrEn = ($urandom % 3) == 0;
      wrSel = 2'($urandom);
      wrData = $urandom;
      rdSel = 2'($urandom);
      msgReady = ($urandom % 4) == 0;
      if (k % 50 == 0) selfId = 8'($urandom % 10);
    end
    @(negedge clk); #1; wrEn = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule